// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register storage of a small processor core that runs in seven operating modes: user, fast interrupt, normal interrupt, supervisor, abort, undefined and system. Thirty-one general-purpose registers and six status words sit behind a sixteen-entry view. That view is remapped on every access by the mode field of the current status word. Low registers are common to all modes. The upper ones switch to a private copy depending on the mode. Index 15 is always the program counter.

The surrounding pipeline reads two operands and writes one result per cycle by architectural index. It can load the program counter directly and can post a compare result into the flags. It raises exception entry and exception return as single-cycle requests. Entry saves the current status into the target mode's saved-status slot, switches the mode, masks interrupts and deposits a return address in that mode's link register. Return restores the status word and reloads the program counter from the link register in the same edge.

Top module: `bankrf_top`

## Requirements
- R1: After reset every general register and the program counter read zero, every saved-status slot is zero, and the current status word is 0x000000D3 (supervisor mode, both interrupt masks set).
- R2: Indices 0 to 7 name the same storage in every mode.
- R3: Indices 8 to 12 select a private copy in fast-interrupt mode; all other modes share one common copy.
- R4: Indices 13 (stack pointer) and 14 (link register) each have six copies: one shared by user and system, and one each for fast interrupt, interrupt, supervisor, abort and undefined.
- R5: Index 15 reads and writes the program counter. A program-counter port write in the same cycle takes priority over a write-port write to index 15.
- R6: A read of a register in the cycle it is written returns the old value. The new value is visible from the next cycle.
- R7: Status bits [4:0] are the mode field, with user=0x10, fast interrupt=0x11, interrupt=0x12, supervisor=0x13, abort=0x17, undefined=0x1B and system=0x1F. Any other code behaves as user.
- R8: Each of the five exception modes has a saved-status slot, read and written through the saved-status port. In user, system or unrecognised modes the port reads zero and writes are ignored.
- R9: An entry request whose target code is one of the five exception modes does four things. It copies the status word into that mode's saved slot, sets the mode field to the target, sets bit 7 (interrupt mask) and, for fast interrupt, bit 6 (fast mask). It also writes the return address into the target's link register, leaving other status bits unchanged. A request naming any other code has no effect.
- R10: A return request in an exception mode copies that mode's saved slot into the status word and that mode's link register into the program counter. In user, system or unrecognised modes it has no effect.
- R11: A compare of A and B sets bit 31 (N) to bit 31 of A minus B and bit 30 (Z) to one exactly when A equals B, leaving other status bits unchanged.
- R12: Status-word updates rank entry over return, over a direct status write, over a compare. An entry blocks a saved-status write in the same cycle. The entry's link-register write wins over a write-port write to the same storage. The write port is decoded with the mode held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port architectural index |
| wr_data | input | DATA_W | Write port data |
| pc_wr_en | input | 1 | Program-counter load enable |
| pc_wr_data | input | DATA_W | Program-counter load value |
| pc_q | output | DATA_W | Current program counter |
| cmp_en | input | 1 | Post a compare result into N and Z |
| cmp_a | input | DATA_W | Compare minuend |
| cmp_b | input | DATA_W | Compare subtrahend |
| cpsr_wr_en | input | 1 | Direct status-word write enable |
| cpsr_wr_data | input | 32 | Direct status-word write value |
| cpsr_q | output | 32 | Current status word |
| spsr_wr_en | input | 1 | Saved-status write enable (current mode) |
| spsr_wr_data | input | 32 | Saved-status write value |
| spsr_q | output | 32 | Saved status of the current mode |
| exc_en | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode code for entry |
| exc_ret_addr | input | DATA_W | Return address placed in the target link register |
| ret_en | input | 1 | Exception return request |

## Verification
The bench places marker values in the same index under different modes. It expects each mode to see only its own copy. A remap that merged user and fast-interrupt upper registers, or that let system mode see a separate stack pointer, would return the wrong marker. Entry and return are driven from user mode with flags already set, and the bench expects the flags to survive in the saved slot and come back on return. A design that reloaded the wrong slot or forgot the fast mask would give a different status word. Collisions are exercised directly: a program-counter load against a write to index 15, a read against a write of the same index, and an entry against a status write and a link-register write in the old mode. Ignored requests (entry to system, return from user, saved-status writes in user) are each followed by a readback showing nothing moved.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

    localparam int AIDX_W      = 4;
    localparam int STAT_W      = 32;
    localparam int MODE_W      = 5;
    localparam int SHARED_N    = 8;
    localparam int HI_N        = 5;
    localparam int NUM_BANKS   = 6;
    localparam int NUM_SPSR    = NUM_BANKS - 1;
    localparam int FIQ_HI_BASE = SHARED_N + HI_N;
    localparam int SPLR_BASE   = FIQ_HI_BASE + HI_N;
    localparam int PC_PHYS     = SPLR_BASE + 2 * NUM_BANKS;
    localparam int PHYS_GPR    = PC_PHYS + 1;
    localparam int PIDX_W      = $clog2(PHYS_GPR);
    localparam int SP_IDX      = 13;
    localparam int LR_IDX      = 14;
    localparam int PC_IDX      = 15;

    localparam int BIT_N = 31;
    localparam int BIT_Z = 30;
    localparam int BIT_I = 7;
    localparam int BIT_F = 6;

    localparam logic [MODE_W-1:0] M_USR = 5'h10;
    localparam logic [MODE_W-1:0] M_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] M_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] M_SVC = 5'h13;
    localparam logic [MODE_W-1:0] M_ABT = 5'h17;
    localparam logic [MODE_W-1:0] M_UND = 5'h1B;
    localparam logic [MODE_W-1:0] M_SYS = 5'h1F;

    localparam logic [STAT_W-1:0] STAT_RESET = 32'h0000_00D3;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
        case (m)
            M_FIQ:   return BK_FIQ;
            M_IRQ:   return BK_IRQ;
            M_SVC:   return BK_SVC;
            M_ABT:   return BK_ABT;
            M_UND:   return BK_UND;
            default: return BK_USR;
        endcase
    endfunction

endpackage

// File: rtl/bankrf_remap.sv
module bankrf_remap
    import bankrf_pkg::*;
(
    input  logic [AIDX_W-1:0] arch_idx,
    input  bank_e             bank,
    output logic [PIDX_W-1:0] phys_idx
);

    logic [PIDX_W-1:0] arch_w;
    logic [PIDX_W-1:0] pair_off;

    always_comb begin
        arch_w   = PIDX_W'(arch_idx);
        pair_off = PIDX_W'({bank, 1'b0}) + PIDX_W'(arch_idx == AIDX_W'(LR_IDX));
        if (int'(arch_idx) < SHARED_N) begin
            phys_idx = arch_w;
        end else if (int'(arch_idx) < SHARED_N + HI_N) begin
            phys_idx = (bank == BK_FIQ) ? arch_w + PIDX_W'(HI_N) : arch_w;
        end else if (int'(arch_idx) < PC_IDX) begin
            phys_idx = PIDX_W'(SPLR_BASE) + pair_off;
        end else begin
            phys_idx = PIDX_W'(PC_PHYS);
        end
    end

endmodule

// File: rtl/bankrf_gpr.sv
module bankrf_gpr
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_RD   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_RD-1:0][PIDX_W-1:0]    rd_phys,
    output logic [N_RD-1:0][DATA_W-1:0]    rd_data,
    input  logic                           wr_en,
    input  logic [PIDX_W-1:0]              wr_phys,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           lr_en,
    input  logic [PIDX_W-1:0]              lr_phys,
    input  logic [DATA_W-1:0]              lr_data,
    input  logic                           pc_en,
    input  logic [DATA_W-1:0]              pc_data,
    output logic [DATA_W-1:0]              pc_out
);

    typedef struct packed {
        logic [PHYS_GPR-1:0][DATA_W-1:0] regs;
    } gpr_state_t;

    gpr_state_t st_d, st_q;

    // later assignments take priority: write port, then entry link, then PC port
    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_phys) < PHYS_GPR)) begin
            st_d.regs[wr_phys] = wr_data;
        end
        if (lr_en && (int'(lr_phys) < PHYS_GPR)) begin
            st_d.regs[lr_phys] = lr_data;
        end
        if (pc_en) begin
            st_d.regs[PC_PHYS] = pc_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        assign rd_data[g] = (int'(rd_phys[g]) < PHYS_GPR) ? st_q.regs[rd_phys[g]] : '0;
    end

    assign pc_out = st_q.regs[PC_PHYS];

endmodule

// File: rtl/bankrf_status.sv
module bankrf_status
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpsr_wr_en,
    input  logic [STAT_W-1:0] cpsr_wr_data,
    input  logic              spsr_wr_en,
    input  logic [STAT_W-1:0] spsr_wr_data,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              exc_req,
    input  logic [MODE_W-1:0] exc_mode,
    input  logic              ret_req,
    output logic [STAT_W-1:0] cpsr_out,
    output logic [STAT_W-1:0] spsr_out,
    output bank_e             cur_bank,
    output bank_e             tgt_bank,
    output logic              exc_fire,
    output logic              ret_fire
);

    typedef struct packed {
        logic [STAT_W-1:0]                cpsr;
        logic [NUM_SPSR-1:0][STAT_W-1:0]  spsr;
    } stat_state_t;

    stat_state_t       st_d, st_q;
    logic [2:0]        cur_slot;
    logic [2:0]        tgt_slot;
    logic [DATA_W-1:0] diff;

    always_comb begin
        cur_bank = bank_of(st_q.cpsr[MODE_W-1:0]);
        tgt_bank = bank_of(exc_mode);
        cur_slot = 3'(cur_bank) - 3'd1;
        tgt_slot = 3'(tgt_bank) - 3'd1;
        exc_fire = exc_req && (tgt_bank != BK_USR);
        ret_fire = ret_req && !exc_fire && (cur_bank != BK_USR);
        spsr_out = (cur_bank == BK_USR) ? '0 : st_q.spsr[cur_slot];
        diff     = cmp_a - cmp_b;

        st_d = st_q;
        if (exc_fire) begin
            st_d.spsr[tgt_slot]           = st_q.cpsr;
            st_d.cpsr[MODE_W-1:0]         = exc_mode;
            st_d.cpsr[BIT_I]              = 1'b1;
            if (tgt_bank == BK_FIQ) begin
                st_d.cpsr[BIT_F]          = 1'b1;
            end
        end else begin
            if (ret_fire) begin
                st_d.cpsr = spsr_out;
            end else if (cpsr_wr_en) begin
                st_d.cpsr = cpsr_wr_data;
            end else if (cmp_en) begin
                st_d.cpsr[BIT_N] = diff[DATA_W-1];
                st_d.cpsr[BIT_Z] = (cmp_a == cmp_b);
            end
            if (spsr_wr_en && (cur_bank != BK_USR)) begin
                st_d.spsr[cur_slot] = spsr_wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cpsr <= STAT_RESET;
            st_q.spsr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpsr_out = st_q.cpsr;

endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pc_wr_en,
    input  logic [DATA_W-1:0] pc_wr_data,
    output logic [DATA_W-1:0] pc_q,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              cpsr_wr_en,
    input  logic [31:0]       cpsr_wr_data,
    output logic [31:0]       cpsr_q,
    input  logic              spsr_wr_en,
    input  logic [31:0]       spsr_wr_data,
    output logic [31:0]       spsr_q,
    input  logic              exc_en,
    input  logic [4:0]        exc_mode,
    input  logic [DATA_W-1:0] exc_ret_addr,
    input  logic              ret_en
);

    localparam int N_MAP = 5;   // rd A, rd B, write, current link, target link
    localparam int N_RD  = 3;   // rd A, rd B, current link

    bank_e                           cur_bank;
    bank_e                           tgt_bank;
    logic                            exc_fire;
    logic                            ret_fire;
    logic [N_MAP-1:0][AIDX_W-1:0]    map_arch;
    bank_e                           map_bank [N_MAP];
    logic [N_MAP-1:0][PIDX_W-1:0]    map_phys;
    logic [N_RD-1:0][PIDX_W-1:0]     rd_phys;
    logic [N_RD-1:0][DATA_W-1:0]     rd_data;
    logic                            pc_en;
    logic [DATA_W-1:0]               pc_next;

    bankrf_status #(.DATA_W(DATA_W)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpsr_wr_en   (cpsr_wr_en),
        .cpsr_wr_data (cpsr_wr_data),
        .spsr_wr_en   (spsr_wr_en),
        .spsr_wr_data (spsr_wr_data),
        .cmp_en       (cmp_en),
        .cmp_a        (cmp_a),
        .cmp_b        (cmp_b),
        .exc_req      (exc_en),
        .exc_mode     (exc_mode),
        .ret_req      (ret_en),
        .cpsr_out     (cpsr_q),
        .spsr_out     (spsr_q),
        .cur_bank     (cur_bank),
        .tgt_bank     (tgt_bank),
        .exc_fire     (exc_fire),
        .ret_fire     (ret_fire)
    );

    always_comb begin
        map_arch[0] = rd_a_idx;
        map_arch[1] = rd_b_idx;
        map_arch[2] = wr_idx;
        map_arch[3] = AIDX_W'(LR_IDX);
        map_arch[4] = AIDX_W'(LR_IDX);
        map_bank[0] = cur_bank;
        map_bank[1] = cur_bank;
        map_bank[2] = cur_bank;
        map_bank[3] = cur_bank;
        map_bank[4] = tgt_bank;
    end

    for (genvar g = 0; g < N_MAP; g++) begin : g_map
        bankrf_remap u_remap (
            .arch_idx (map_arch[g]),
            .bank     (map_bank[g]),
            .phys_idx (map_phys[g])
        );
    end

    always_comb begin
        rd_phys[0] = map_phys[0];
        rd_phys[1] = map_phys[1];
        rd_phys[2] = map_phys[3];
        pc_en      = ret_fire || pc_wr_en;
        pc_next    = ret_fire ? rd_data[2] : pc_wr_data;
    end

    bankrf_gpr #(.DATA_W(DATA_W), .N_RD(N_RD)) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_phys (rd_phys),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_phys (map_phys[2]),
        .wr_data (wr_data),
        .lr_en   (exc_fire),
        .lr_phys (map_phys[4]),
        .lr_data (exc_ret_addr),
        .pc_en   (pc_en),
        .pc_data (pc_next),
        .pc_out  (pc_q)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

endmodule

// File: rtl/bankrf_checker.sv
module bankrf_checker
    import bankrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              pc_wr_en,
    input logic [DATA_W-1:0] pc_wr_data,
    input logic [DATA_W-1:0] pc_q,
    input logic              cmp_en,
    input logic              cpsr_wr_en,
    input logic [31:0]       cpsr_q,
    input logic [31:0]       spsr_q,
    input logic              exc_en,
    input logic [4:0]        exc_mode,
    input logic              ret_en
);

    logic entry_ok;
    logic in_plain;
    logic leave_ok;

    assign entry_ok = exc_en && (bank_of(exc_mode) != BK_USR);
    assign in_plain = (bank_of(cpsr_q[4:0]) == BK_USR);
    assign leave_ok = ret_en && !entry_ok && !in_plain;

    a_r9_entry_saves: assert property (@(posedge clk) disable iff (!rst_n)
        entry_ok |=> (cpsr_q[4:0] == $past(exc_mode)) && cpsr_q[BIT_I]
                     && (spsr_q == $past(cpsr_q)));

    a_r9_fast_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_ok && exc_mode == M_FIQ) |=> cpsr_q[BIT_F]);

    a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
        leave_ok |=> (cpsr_q == $past(spsr_q)));

    a_r10_plain_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && in_plain && !entry_ok && !cpsr_wr_en && !cmp_en) |=> $stable(cpsr_q));

    a_r8_no_saved_slot: assert property (@(posedge clk) disable iff (!rst_n)
        in_plain |-> (spsr_q == '0));

    a_r5_pc_view: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 4'd15) |-> (rd_a_data == pc_q));

    a_r5_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_en && !leave_ok) |=> (pc_q == $past(pc_wr_data)));

endmodule

bind bankrf_top bankrf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .pc_wr_en   (pc_wr_en),
    .pc_wr_data (pc_wr_data),
    .pc_q       (pc_q),
    .cmp_en     (cmp_en),
    .cpsr_wr_en (cpsr_wr_en),
    .cpsr_q     (cpsr_q),
    .spsr_q     (spsr_q),
    .exc_en     (exc_en),
    .exc_mode   (exc_mode),
    .ret_en     (ret_en)
);

// File: tb/bankrf_top_test.sv
`timescale 1ns/1ps
module bankrf_top_test;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [W-1:0] rd_a_data, rd_b_data, pc_q;
    logic         wr_en = 0, pc_wr_en = 0, cmp_en = 0, cpsr_wr_en = 0;
    logic         spsr_wr_en = 0, exc_en = 0, ret_en = 0;
    logic [W-1:0] wr_data = '0, pc_wr_data = '0, cmp_a = '0, cmp_b = '0, exc_ret_addr = '0;
    logic [31:0]  cpsr_wr_data = '0, spsr_wr_data = '0, cpsr_q, spsr_q;
    logic [4:0]   exc_mode = '0;

    always #2 clk = ~clk;

    bankrf_top #(.DATA_W(W)) uut (.*);

    typedef struct {
        int          kind;   // 0 rdA, 1 rdB, 2 status, 3 saved, 4 pc
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;

    // monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = rd_a_data;
                1: act = rd_b_data;
                2: act = cpsr_q;
                3: act = spsr_q;
                default: act = pc_q;
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic see_reg(logic [3:0] idx, logic [31:0] exp, string tag);
        rd_a_idx = idx;
        push(0, exp, tag);
        tick();
    endtask

    task automatic see_stat(logic [31:0] cp, logic [31:0] sp, string tag);
        push(2, cp, tag);
        push(3, sp, tag);
        tick();
    endtask

    task automatic see_pc(logic [31:0] exp, string tag);
        push(4, exp, tag);
        tick();
    endtask

    task automatic put_reg(logic [3:0] idx, logic [31:0] d);
        wr_en = 1; wr_idx = idx; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic put_stat(logic [31:0] v);
        cpsr_wr_en = 1; cpsr_wr_data = v;
        tick();
        cpsr_wr_en = 0;
    endtask

    task automatic put_saved(logic [31:0] v);
        spsr_wr_en = 1; spsr_wr_data = v;
        tick();
        spsr_wr_en = 0;
    endtask

    task automatic compare(logic [31:0] a, logic [31:0] b);
        cmp_en = 1; cmp_a = a; cmp_b = b;
        tick();
        cmp_en = 0;
    endtask

    task automatic enter(logic [4:0] m, logic [31:0] addr);
        exc_en = 1; exc_mode = m; exc_ret_addr = addr;
        tick();
        exc_en = 0;
    endtask

    task automatic leave();
        ret_en = 1;
        tick();
        ret_en = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        see_stat(32'h0000_00D3, 32'h0, "R1 status after reset");
        see_pc(32'h0, "R1 pc after reset");
        see_reg(4'd0, 32'h0, "R1 r0 after reset");
        see_reg(4'd13, 32'h0, "R1 sp after reset");

        // supervisor markers
        put_reg(4'd0, 32'hA0);
        put_reg(4'd8, 32'h800);
        put_reg(4'd13, 32'h5C13);
        put_reg(4'd14, 32'h5C14);

        // user mode
        put_stat(32'h10);
        see_reg(4'd0, 32'hA0, "R2 r0 shared svc->usr");
        see_reg(4'd8, 32'h800, "R3 r8 common copy");
        see_reg(4'd13, 32'h0, "R4 user sp distinct from svc");
        see_stat(32'h10, 32'h0, "R8 no saved slot in user");
        put_saved(32'h1234);
        see_stat(32'h10, 32'h0, "R8 saved write ignored in user");
        put_reg(4'd13, 32'h13);

        // system shares user bank
        put_stat(32'h1F);
        see_reg(4'd13, 32'h13, "R4 system sees user sp");

        // fast interrupt private upper registers
        put_stat(32'hD1);
        see_reg(4'd8, 32'h0, "R3 fiq private r8");
        put_reg(4'd8, 32'hF8);
        see_reg(4'd0, 32'hA0, "R2 r0 shared in fiq");
        see_reg(4'd13, 32'h0, "R4 fiq own sp");

        // back to supervisor
        put_stat(32'hD3);
        see_reg(4'd8, 32'h800, "R3 svc untouched by fiq write");
        see_reg(4'd13, 32'h5C13, "R4 svc sp kept");
        see_reg(4'd14, 32'h5C14, "R4 svc lr kept");

        // unrecognised mode behaves as user
        put_stat(32'h15);
        see_reg(4'd13, 32'h13, "R7 invalid mode maps to user sp");
        see_stat(32'h15, 32'h0, "R7 invalid mode has no saved slot");

        // compares in user mode
        put_stat(32'h10);
        compare(32'd5, 32'd7);
        see_stat(32'h8000_0010, 32'h0, "R11 5-7 negative");
        compare(32'd16, 32'd3);
        see_stat(32'h0000_0010, 32'h0, "R11 16-3 positive");
        compare(32'd9, 32'd9);
        see_stat(32'h4000_0010, 32'h0, "R11 9-9 equal");

        // interrupt entry and return
        enter(5'h12, 32'h100);
        see_stat(32'h4000_0092, 32'h4000_0010, "R9 irq entry status");
        see_reg(4'd14, 32'h100, "R9 irq link gets return address");
        see_reg(4'd13, 32'h0, "R4 irq own sp");
        leave();
        see_stat(32'h4000_0010, 32'h0, "R10 irq return restores status");
        see_pc(32'h100, "R10 irq return loads pc");
        see_reg(4'd14, 32'h0, "R10 user lr untouched");

        // fast interrupt entry and return
        enter(5'h11, 32'h200);
        see_stat(32'h4000_00D1, 32'h4000_0010, "R9 fiq entry sets both masks");
        see_reg(4'd8, 32'hF8, "R3 fiq copy kept across modes");
        leave();
        see_stat(32'h4000_0010, 32'h0, "R10 fiq return restores status");
        see_pc(32'h200, "R10 fiq return loads pc");

        // ignored requests
        enter(5'h1F, 32'h900);
        see_stat(32'h4000_0010, 32'h0, "R9 entry to system ignored");
        see_reg(4'd14, 32'h0, "R9 ignored entry leaves lr");
        leave();
        see_stat(32'h4000_0010, 32'h0, "R10 return in user ignored");
        see_pc(32'h200, "R10 return in user keeps pc");

        // program counter collisions
        pc_wr_en = 1; pc_wr_data = 32'h400;
        wr_en = 1; wr_idx = 4'd15; wr_data = 32'h999;
        tick();
        pc_wr_en = 0; wr_en = 0;
        see_pc(32'h400, "R5 pc port beats write port");
        put_reg(4'd15, 32'h444);
        see_reg(4'd15, 32'h444, "R5 index 15 reads pc");
        see_pc(32'h444, "R5 write port loads pc");

        // read during write
        wr_en = 1; wr_idx = 4'd5; wr_data = 32'h55;
        rd_b_idx = 4'd5;
        push(1, 32'h0, "R6 same-cycle read returns old");
        tick();
        wr_en = 0;
        push(1, 32'h55, "R6 new value next cycle");
        tick();

        // entry beats status write; write port uses old mode
        exc_en = 1; exc_mode = 5'h17; exc_ret_addr = 32'h300;
        cpsr_wr_en = 1; cpsr_wr_data = 32'h1F;
        wr_en = 1; wr_idx = 4'd14; wr_data = 32'h777;
        tick();
        exc_en = 0; cpsr_wr_en = 0; wr_en = 0;
        see_stat(32'h4000_0097, 32'h4000_0010, "R12 entry wins over status write");
        see_reg(4'd14, 32'h300, "R12 abort lr from entry");
        put_saved(32'hABCD);
        see_stat(32'h4000_0097, 32'hABCD, "R8 saved write in abort");
        leave();
        see_stat(32'h0000_ABCD, 32'h0, "R10 return reloads written slot");
        see_pc(32'h300, "R10 abort return pc");
        see_reg(4'd14, 32'h777, "R12 write port used old mode");

        tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule